// File: doc/BRIEF.md
# Transmit Slip Buffer with Settable Delay

This block sits between a backplane channel stream and a T1 line frame. The backplane side deposits channel octets into a 24-entry store, one entry per timeslot. The line side walks a 193-bit frame on a bit-period strobe. The frame is 24 octets of 8 bits followed by one framing bit. At the first bit of each timeslot the line side emits that slot's stored octet. The line frame boundary is generated internally and runs freely from reset.

A configuration write sets the write-to-read delay once. It takes effect on the next backplane write of timeslot 1, which is entry 0. The block counts line bit periods from that write and restarts the line frame at the programmed count, so timeslot 1 is read exactly that many bit periods after it was stored. After that single realignment the boundary runs freely again. A zero value is ignored. Values that would reach a full frame are limited.

Top module: `tx_slip_buffer`

## Requirements
- R1: After reset the octet-valid and frame-start outputs are low, and the first line bit strobe produces a frame start together with an octet for slot 0.
- R2: Without realignment, frame starts occur every 193 line bit strobes. Position 192 of each frame is the framing bit, which emits no octet.
- R3: Outputs follow the strobe by one clock. At frame position 8k, for k from 0 to 23, the block emits slot index k with the octet last written to entry k. A read in the same clock as a write to the same entry returns the older octet.
- R4: A backplane write stores its octet at the entry given by its slot index. A write with a slot index of 24 or more leaves every stored octet unchanged.
- R5: A non-zero configuration write arms the realignment. The first write to entry 0 that follows it starts a count of line bit strobes, beginning with the first strobe in a later clock. The D-th such strobe is emitted at frame position 0. Later positions continue from there.
- R6: Configuration values above 192 act as 192, so the delay is always less than one 193-bit frame.
- R7: A configuration write of zero changes nothing: no arming, no change to the stored delay, and no move of the frame boundary.
- R8: The realignment happens once. Later writes to entry 0 without a new configuration write leave the 193-strobe frame period in place.
- R9: A non-zero configuration write made while a count is running cancels that count. The block re-arms with the new value and waits for the next write to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_wr_en | input | 1 | Backplane octet write strobe |
| bp_wr_slot | input | 5 | Backplane timeslot index, 0 = timeslot 1 |
| bp_wr_data | input | 8 | Backplane octet |
| cfg_wr | input | 1 | Delay configuration write strobe |
| cfg_delay | input | 8 | Delay in line bit periods |
| line_tick | input | 1 | One pulse per line bit period |
| line_frame | output | 1 | Pulse: this strobe was frame position 0 |
| line_oct_valid | output | 1 | Pulse: an octet is presented |
| line_oct_slot | output | 5 | Slot index of the presented octet |
| line_oct_data | output | 8 | Presented octet |

## Verification
The hardest case to reach is the realignment landing at a chosen frame position. That position depends on three things: the phase of the free-running frame when the delay is armed, the moment entry 0 is next written, and the delay value itself, including the values near and above the one-frame limit. The stimulus writes entries in rotation on the clocks between line strobes, so the write to entry 0 falls at many different frame phases. It then sweeps the delay from 1 to 12, takes mid-range and 185 to 200 values and 255, applies a zero write, and re-arms once while a count is in progress. A running model of position, arming state and stored octets predicts every strobe's outputs.

// File: rtl/tsb_pkg.sv
// Package: shared types for the transmit slip buffer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package tsb_pkg;

    // Realignment controller states.
    typedef enum logic [1:0] {
        ALN_IDLE  = 2'd0,
        ALN_ARMED = 2'd1,
        ALN_COUNT = 2'd2
    } align_state_e;

endpackage

// File: rtl/tsb_octet_store.sv
// Octet store: one entry per timeslot, written from the backplane side and
// read with a registered port from the line side.
// Assumes: out-of-range write indices must be dropped; a read and a write
// in the same clock return the old content.
module tsb_octet_store #(
    parameter int SLOTS = 24,
    parameter int OCT_W = 8,
    parameter int SW    = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [SW-1:0]    wr_addr,
    input  logic [OCT_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [SW-1:0]    rd_addr,
    output logic [OCT_W-1:0] rd_data
);

    logic [OCT_W-1:0] mem [SLOTS];
    logic             wr_ok;

    // Accept only indices that address a real entry.
    always_comb begin
        wr_ok = wr_en && (wr_addr < SW'(SLOTS));
    end

    // Store one octet per accepted write.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read: the value present before this edge.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/tsb_align_ctl.sv
// Realignment controller: latches a clamped delay on a non-zero
// configuration write, waits for the next write of entry 0, then counts
// line strobes and raises force_o on the strobe that must become frame
// position 0. Assumes force_o is used combinationally by the line timer.
module tsb_align_ctl
    import tsb_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int LIMIT = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             slot0_wr,
    input  logic             tick,
    output logic             force_o
);

    localparam logic [DLY_W-1:0] LIM_V = DLY_W'(LIMIT);

    align_state_e     state_q;
    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] remain_q;
    logic             cfg_take;
    logic [DLY_W-1:0] cfg_clamped;

    // Decode a usable configuration write and limit it below one frame.
    always_comb begin
        cfg_take    = cfg_wr && (cfg_delay != '0);
        cfg_clamped = (cfg_delay > LIM_V) ? LIM_V : cfg_delay;
        force_o     = (state_q == ALN_COUNT) && tick && (remain_q == DLY_W'(1));
    end

    // Arm, count and release the one-time realignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ALN_IDLE;
            dly_q    <= DLY_W'(1);
            remain_q <= DLY_W'(1);
        end else if (cfg_take) begin
            state_q <= ALN_ARMED;
            dly_q   <= cfg_clamped;
        end else begin
            case (state_q)
                ALN_ARMED: begin
                    if (slot0_wr) begin
                        state_q  <= ALN_COUNT;
                        remain_q <= dly_q;
                    end
                end
                ALN_COUNT: begin
                    if (tick) begin
                        if (remain_q == DLY_W'(1)) begin
                            state_q <= ALN_IDLE;
                        end else begin
                            remain_q <= remain_q - DLY_W'(1);
                        end
                    end
                end
                default: state_q <= ALN_IDLE;
            endcase
        end
    end

    // R6: a running count never exceeds the limit and never reaches zero.
    p_remain_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ALN_COUNT) |-> (remain_q >= DLY_W'(1) && remain_q <= LIM_V));

    // R7: a zero write leaves the stored delay untouched.
    p_zero_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_delay == '0) |=> $stable(dly_q));

    // R8: after the forced boundary the controller rests unless re-armed.
    p_force_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_o && !cfg_take) |=> (state_q == ALN_IDLE));

    // R9: a usable write while counting returns to waiting for entry 0.
    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_take && state_q == ALN_COUNT) |=> (state_q == ALN_ARMED));

endmodule

// File: rtl/tsb_line_timer.sv
// Line timer: walks the 193-position line frame (SLOTS octets of OCT_W bits
// plus one framing bit) on each strobe, and restarts at position 0 when
// force_i is high. Issues the store read and the registered output pulses.
// Assumes tick is a single-clock pulse per bit period.
module tsb_line_timer #(
    parameter int SLOTS = 24,
    parameter int OCT_W = 8,
    parameter int SW    = $clog2(SLOTS + 1),
    parameter int BW    = (OCT_W > 1) ? $clog2(OCT_W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          force_i,
    output logic          rd_en,
    output logic [SW-1:0] rd_addr,
    output logic          frame_o,
    output logic          valid_o,
    output logic [SW-1:0] slot_o
);

    logic [SW-1:0] slot_q;
    logic [BW-1:0] bit_q;
    logic [SW-1:0] cur_slot;
    logic [BW-1:0] cur_bit;
    logic          cur_data;

    // Position used by this strobe, with the forced restart applied.
    always_comb begin
        cur_slot = force_i ? '0 : slot_q;
        cur_bit  = force_i ? '0 : bit_q;
        cur_data = (cur_bit == '0) && (cur_slot < SW'(SLOTS));
        rd_en    = tick && cur_data;
        rd_addr  = cur_slot;
    end

    // Advance the frame position once per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            bit_q  <= '0;
        end else if (tick) begin
            if (cur_slot == SW'(SLOTS)) begin
                slot_q <= '0;
                bit_q  <= '0;
            end else if (cur_bit == BW'(OCT_W - 1)) begin
                slot_q <= cur_slot + SW'(1);
                bit_q  <= '0;
            end else begin
                slot_q <= cur_slot;
                bit_q  <= cur_bit + BW'(1);
            end
        end
    end

    // Register the per-strobe output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_o <= 1'b0;
            valid_o <= 1'b0;
            slot_o  <= '0;
        end else begin
            frame_o <= tick && (cur_slot == '0) && (cur_bit == '0);
            valid_o <= tick && cur_data;
            if (tick) begin
                slot_o <= cur_slot;
            end
        end
    end

    // R2: the stored position stays inside the frame; framing bit has one position.
    p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q <= SW'(SLOTS)) && ((slot_q == SW'(SLOTS)) -> (bit_q == '0)));

    // R5: a forced strobe is reported as a frame start.
    p_realign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && force_i) |=> frame_o);

endmodule

// File: rtl/tx_slip_buffer.sv
// Transmit slip buffer top: octet store, line timer and one-time
// realignment controller. Assumes one clock for both sides, with the
// line bit period given as a strobe.
module tx_slip_buffer #(
    parameter int SLOTS = 24,
    parameter int OCT_W = 8,
    parameter int DLY_W = 8,
    parameter int SW    = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bp_wr_en,
    input  logic [SW-1:0]    bp_wr_slot,
    input  logic [OCT_W-1:0] bp_wr_data,
    input  logic             cfg_wr,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             line_tick,
    output logic             line_frame,
    output logic             line_oct_valid,
    output logic [SW-1:0]    line_oct_slot,
    output logic [OCT_W-1:0] line_oct_data
);

    localparam int LIMIT = SLOTS * OCT_W;

    logic          force_w;
    logic          rd_en_w;
    logic [SW-1:0] rd_addr_w;
    logic          slot0_wr_w;

    // Detect the backplane write of timeslot 1.
    always_comb begin
        slot0_wr_w = bp_wr_en && (bp_wr_slot == '0);
    end

    tsb_octet_store #(.SLOTS(SLOTS), .OCT_W(OCT_W), .SW(SW)) u_store (
        .clk     (clk),
        .wr_en   (bp_wr_en),
        .wr_addr (bp_wr_slot),
        .wr_data (bp_wr_data),
        .rd_en   (rd_en_w),
        .rd_addr (rd_addr_w),
        .rd_data (line_oct_data)
    );

    tsb_align_ctl #(.DLY_W(DLY_W), .LIMIT(LIMIT)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_delay (cfg_delay),
        .slot0_wr  (slot0_wr_w),
        .tick      (line_tick),
        .force_o   (force_w)
    );

    tsb_line_timer #(.SLOTS(SLOTS), .OCT_W(OCT_W), .SW(SW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (line_tick),
        .force_i (force_w),
        .rd_en   (rd_en_w),
        .rd_addr (rd_addr_w),
        .frame_o (line_frame),
        .valid_o (line_oct_valid),
        .slot_o  (line_oct_slot)
    );

    // R1: outputs are single-clock pulses that follow a strobe only.
    p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> (!line_frame && !line_oct_valid));

    // R3: a presented octet always carries a real slot index.
    p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        line_oct_valid |-> (line_oct_slot < SW'(SLOTS)));

endmodule

// File: tb/sim_tx_slip_buffer.sv
module sim_tx_slip_buffer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bp_wr_en = 1'b0;
    logic [4:0] bp_wr_slot = '0;
    logic [7:0] bp_wr_data = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_delay = '0;
    logic       line_tick = 1'b0;
    logic       line_frame;
    logic       line_oct_valid;
    logic [4:0] line_oct_slot;
    logic [7:0] line_oct_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state.
    int m_pos = 0;
    int m_st = 0;
    int m_dly = 1;
    int m_rem = 1;
    int m_mem [24];
    bit m_init [24];
    int wcnt = 0;

    always #10 clk = ~clk;

    tx_slip_buffer u0 (
        .clk(clk), .rst_n(rst_n),
        .bp_wr_en(bp_wr_en), .bp_wr_slot(bp_wr_slot), .bp_wr_data(bp_wr_data),
        .cfg_wr(cfg_wr), .cfg_delay(cfg_delay), .line_tick(line_tick),
        .line_frame(line_frame), .line_oct_valid(line_oct_valid),
        .line_oct_slot(line_oct_slot), .line_oct_data(line_oct_data)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, predict, compare at the next negedge.
    task automatic step(input bit tk, input bit we, input int ws, input int wd,
                        input bit cw, input int cv, input string tag);
        bit f;
        int use_pos;
        bit e_frame, e_valid;
        int e_slot, e_data;
        bit e_dchk;
        line_tick  = tk;
        bp_wr_en   = we;
        bp_wr_slot = 5'(ws);
        bp_wr_data = 8'(wd);
        cfg_wr     = cw;
        cfg_delay  = 8'(cv);
        f = (m_st == 2) && tk && (m_rem == 1);
        use_pos = f ? 0 : m_pos;
        e_frame = tk && (use_pos == 0);
        e_valid = tk && (use_pos % 8 == 0) && (use_pos < 192);
        e_slot  = use_pos / 8;
        e_dchk  = e_valid && m_init[e_slot % 24];
        e_data  = e_dchk ? m_mem[e_slot] : 0;
        if (tk) m_pos = (use_pos == 192) ? 0 : use_pos + 1;
        if (cw && cv != 0) begin
            m_st = 1;
            m_dly = (cv > 192) ? 192 : cv;
        end else if (m_st == 1 && we && ws == 0) begin
            m_st = 2;
            m_rem = m_dly;
        end else if (m_st == 2 && tk) begin
            if (m_rem == 1) m_st = 0;
            else m_rem--;
        end
        if (we && ws < 24) begin
            m_mem[ws] = wd;
            m_init[ws] = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        cmp(tag, "frame", int'(line_frame), int'(e_frame));
        cmp(tag, "valid", int'(line_oct_valid), int'(e_valid));
        if (e_valid) cmp(tag, "slot", int'(line_oct_slot), e_slot);
        if (e_dchk) cmp(tag, "data", int'(line_oct_data), e_data);
    endtask

    // n strobes; the clock between strobes carries a rotating octet write.
    task automatic run(input int n, input bit wr, input string tag);
        for (int i = 0; i < n; i++) begin
            if (wr) begin
                step(1'b0, 1'b1, wcnt % 24, (wcnt * 37 + 11) % 256, 1'b0, 0, tag);
                wcnt++;
            end else begin
                step(1'b0, 1'b0, 0, 0, 1'b0, 0, tag);
            end
            step(1'b1, 1'b0, 0, 0, 1'b0, 0, tag);
        end
    endtask

    task automatic cfg(input int v, input string tag);
        step(1'b0, 1'b0, 0, 0, 1'b1, v, tag);
    endtask

    initial begin
        for (int i = 0; i < 24; i++) begin
            m_init[i] = 1'b0;
            m_mem[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and first strobe.
        cmp("R1", "frame after reset", int'(line_frame), 0);
        cmp("R1", "valid after reset", int'(line_oct_valid), 0);
        step(1'b1, 1'b0, 0, 0, 1'b0, 0, "R1");
        // R4: fill all entries, then attempt out-of-range writes.
        for (int s = 0; s < 24; s++) step(1'b0, 1'b1, s, s * 9 + 3, 1'b0, 0, "R4");
        for (int s = 24; s < 32; s++) step(1'b0, 1'b1, s, 255 - s, 1'b0, 0, "R4");
        run(200, 1'b0, "R4");
        // R2, R3: free-running frames with rotating writes.
        run(400, 1'b1, "R2");
        run(200, 1'b1, "R3");
        // R5: sweep delays.
        for (int d = 1; d <= 12; d++) begin
            cfg(d, "R5");
            run(240, 1'b1, "R5");
        end
        cfg(60, "R5");  run(240, 1'b1, "R5");
        cfg(100, "R5"); run(240, 1'b1, "R5");
        cfg(150, "R5"); run(240, 1'b1, "R5");
        for (int d = 185; d <= 192; d++) begin
            cfg(d, "R5");
            run(240, 1'b1, "R5");
        end
        // R6: values above the limit.
        for (int d = 193; d <= 200; d++) begin
            cfg(d, "R6");
            run(240, 1'b1, "R6");
        end
        cfg(255, "R6"); run(240, 1'b1, "R6");
        // R7: zero write ignored, both idle and while armed.
        cfg(0, "R7"); run(240, 1'b1, "R7");
        cfg(33, "R7"); cfg(0, "R7"); run(240, 1'b1, "R7");
        // R8: many later entry-0 writes, no further realignment.
        run(600, 1'b1, "R8");
        // R9: re-arm while counting.
        cfg(150, "R9");
        run(30, 1'b1, "R9");
        cfg(7, "R9");
        run(260, 1'b1, "R9");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule